// File: doc/BRIEF.md
# Lockstep Result Comparator with Tolerance and Gap Timer

This block watches two software threads that run the same task and report their results on their own. Each thread writes a signed result and a checkpoint tag through its own write-strobe port. When both halves of a pair are present, the block compares them. Agreement is defined as a difference no larger than a programmable tolerance, because one thread may run a cheaper and less exact algorithm. Neither thread ever waits for the other. The hardware holds the first half until the second half arrives.

A programmable gap limit bounds how far one thread may run ahead of the other. If the second half does not arrive in time, the block raises a timeout, drops the pending half and returns to idle. A tag mismatch between the halves, or a repeated submission from the same side, raises a sequence error. All three error flags are sticky and are cleared by writing ones to them. A status vector also shows which side, if any, is waiting for its partner.

Top module: `lockstep_cmp`

## Requirements
- R1: When both ports write in the same cycle with equal tags, mismatchErr rises after that clock edge exactly when the absolute value of the signed difference of the two 32-bit results is greater than the tolerance. The tolerance is taken as an unsigned 32-bit value.
- R2: The tolerance is written through tolWe/tolIn and is inclusive: a difference equal to the tolerance is not an error.
- R3: A lone submission is held and its side is shown in statusOut. Bit 3 means a result from port A is waiting; bit 4 means a result from port B is waiting. A later submission from the other port completes the pair, is compared as in R1 against the held result, and clears the waiting bit.
- R4: If the two tags of a pair differ, seqErr is set and no magnitude check is made for that pair.
- R5: A second submission from the same port while that port's result is waiting sets seqErr. The new result and tag replace the held ones, and the gap window restarts.
- R6: With gap limit G (written through gapWe/gapIn), a partner is accepted on any clock edge up to G edges after the edge that captured the first half. If it has not arrived by then, timeoutErr is set on edge G+1, the waiting bit clears, and any submission sampled on that edge is discarded.
- R7: Error flags are sticky. clrWe with clrMask clears the flags whose mask bit is one: bit 0 is mismatch, bit 1 is timeout, bit 2 is sequence. A flag set on the same edge wins over its clear.
- R8: After reset all flags and waiting bits are zero, the tolerance is 0 and the gap limit is 4.
- R9: If a waiting pair is completed on the same edge that the waiting port submits again, the completed pair is judged and the new submission begins a fresh waiting pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| aWrEn | input | 1 | Port A submission strobe |
| aData | input | 32 | Port A signed result |
| aTag | input | 8 | Port A checkpoint tag |
| bWrEn | input | 1 | Port B submission strobe |
| bData | input | 32 | Port B signed result |
| bTag | input | 8 | Port B checkpoint tag |
| tolWe | input | 1 | Tolerance write strobe |
| tolIn | input | 32 | New tolerance |
| gapWe | input | 1 | Gap limit write strobe |
| gapIn | input | 16 | New gap limit in cycles |
| clrWe | input | 1 | Error clear strobe |
| clrMask | input | 3 | Write-one-to-clear mask: bit 0 mismatch, bit 1 timeout, bit 2 sequence |
| mismatchErr | output | 1 | Sticky out-of-tolerance flag |
| timeoutErr | output | 1 | Sticky gap timeout flag |
| seqErr | output | 1 | Sticky tag or ordering flag |
| statusOut | output | 5 | {B waiting, A waiting, seqErr, timeoutErr, mismatchErr} |

## Verification
The hardest situation to reach is a partner that arrives on the exact edge where the gap window closes. On that edge the timeout has to win and the late result has to be dropped, not paired. The stimulus sweeps every arrival offset from 1 to G+1 for several gap limits, so both sides of that boundary are hit for each limit. The tolerance checks sweep signed extremes against one another, with tolerances of zero, small values and all ones. Half of those pairs arrive split across two cycles, so the held path is used as well as the same-cycle path.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [1:0] {SEL_PORTS, SEL_HELD_B, SEL_HELD_A} cmp_sel_e;
  typedef enum logic [1:0] {ST_IDLE, ST_HOLD_A, ST_HOLD_B} state_e;

  typedef struct packed {
    logic     loadHeld;
    logic     loadFromB;
    logic     cntClr;
    logic     cntInc;
    cmp_sel_e cmpSel;
  } dp_ctrl_t;

  localparam int ERR_N   = 3;
  localparam int ERR_MIS = 0;
  localparam int ERR_TMO = 1;
  localparam int ERR_SEQ = 2;
endpackage

// File: rtl/lsc_datapath.sv
module lsc_datapath
  import lsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8,
  parameter int GAP_W  = 16,
  parameter logic [DATA_W-1:0] TOL_RST = '0,
  parameter logic [GAP_W-1:0]  GAP_RST = GAP_W'(4)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctrl_t          ctrl,
  input  logic [DATA_W-1:0] aData,
  input  logic [TAG_W-1:0]  aTag,
  input  logic [DATA_W-1:0] bData,
  input  logic [TAG_W-1:0]  bTag,
  input  logic              tolWe,
  input  logic [DATA_W-1:0] tolIn,
  input  logic              gapWe,
  input  logic [GAP_W-1:0]  gapIn,
  output logic              overTol,
  output logic              tagDiff,
  output logic              gapHit
);
  localparam int EXT_W = DATA_W + 1;

  logic [DATA_W-1:0] heldData;
  logic [TAG_W-1:0]  heldTag;
  logic [DATA_W-1:0] tolReg;
  logic [GAP_W-1:0]  gapReg;
  logic [GAP_W-1:0]  gapCnt;

  logic [DATA_W-1:0] opX, opY;
  logic [TAG_W-1:0]  tagX, tagY;
  logic [EXT_W-1:0]  diff, mag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldData <= '0;
      heldTag  <= '0;
    end else if (ctrl.loadHeld) begin
      heldData <= ctrl.loadFromB ? bData : aData;
      heldTag  <= ctrl.loadFromB ? bTag  : aTag;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tolReg <= TOL_RST;
      gapReg <= GAP_RST;
    end else begin
      if (tolWe) tolReg <= tolIn;
      if (gapWe) gapReg <= gapIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            gapCnt <= '0;
    else if (ctrl.cntClr) gapCnt <= '0;
    else if (ctrl.cntInc) gapCnt <= gapCnt + 1'b1;
  end

  always_comb begin
    opX  = aData;
    opY  = bData;
    tagX = aTag;
    tagY = bTag;
    unique case (ctrl.cmpSel)
      SEL_HELD_B: begin opX = heldData; tagX = heldTag; end
      SEL_HELD_A: begin opY = heldData; tagY = heldTag; end
      default: ;
    endcase
  end

  // sign-extended subtraction cannot overflow the extra bit
  assign diff    = {opX[DATA_W-1], opX} - {opY[DATA_W-1], opY};
  assign mag     = diff[EXT_W-1] ? (~diff + 1'b1) : diff;
  assign overTol = mag > {1'b0, tolReg};
  assign tagDiff = tagX != tagY;
  assign gapHit  = gapCnt >= gapReg;
endmodule

// File: rtl/lsc_control.sv
module lsc_control
  import lsc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             aWrEn,
  input  logic             bWrEn,
  input  logic             overTol,
  input  logic             tagDiff,
  input  logic             gapHit,
  input  logic             clrWe,
  input  logic [ERR_N-1:0] clrMask,
  output dp_ctrl_t         ctrl,
  output logic [ERR_N-1:0] errFlags,
  output logic             pendA,
  output logic             pendB
);
  state_e state, stateNx;
  logic [ERR_N-1:0] setVec, errQ;
  logic judge;

  always_comb begin
    ctrl    = '{loadHeld: 1'b0, loadFromB: 1'b0, cntClr: 1'b0,
                cntInc: 1'b0, cmpSel: SEL_PORTS};
    stateNx = state;
    setVec  = '0;
    judge   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (aWrEn && bWrEn) begin
          judge = 1'b1;
        end else if (aWrEn || bWrEn) begin
          ctrl.loadHeld  = 1'b1;
          ctrl.loadFromB = bWrEn;
          ctrl.cntClr    = 1'b1;
          stateNx        = bWrEn ? ST_HOLD_B : ST_HOLD_A;
        end
      end
      ST_HOLD_A: begin
        if (gapHit) begin
          setVec[ERR_TMO] = 1'b1;
          stateNx         = ST_IDLE;
        end else if (bWrEn) begin
          ctrl.cmpSel = SEL_HELD_B;
          judge       = 1'b1;
          if (aWrEn) begin
            ctrl.loadHeld = 1'b1;
            ctrl.cntClr   = 1'b1;
          end else begin
            stateNx = ST_IDLE;
          end
        end else if (aWrEn) begin
          setVec[ERR_SEQ] = 1'b1;
          ctrl.loadHeld   = 1'b1;
          ctrl.cntClr     = 1'b1;
        end else begin
          ctrl.cntInc = 1'b1;
        end
      end
      ST_HOLD_B: begin
        if (gapHit) begin
          setVec[ERR_TMO] = 1'b1;
          stateNx         = ST_IDLE;
        end else if (aWrEn) begin
          ctrl.cmpSel = SEL_HELD_A;
          judge       = 1'b1;
          if (bWrEn) begin
            ctrl.loadHeld  = 1'b1;
            ctrl.loadFromB = 1'b1;
            ctrl.cntClr    = 1'b1;
          end else begin
            stateNx = ST_IDLE;
          end
        end else if (bWrEn) begin
          setVec[ERR_SEQ] = 1'b1;
          ctrl.loadHeld   = 1'b1;
          ctrl.loadFromB  = 1'b1;
          ctrl.cntClr     = 1'b1;
        end else begin
          ctrl.cntInc = 1'b1;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
    if (judge) begin
      if (tagDiff)      setVec[ERR_SEQ] = 1'b1;
      else if (overTol) setVec[ERR_MIS] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      errQ  <= '0;
    end else begin
      state <= stateNx;
      errQ  <= (errQ & ~(clrWe ? clrMask : '0)) | setVec;
    end
  end

  assign errFlags = errQ;
  assign pendA    = state == ST_HOLD_A;
  assign pendB    = state == ST_HOLD_B;
endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp
  import lsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8,
  parameter int GAP_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aWrEn,
  input  logic [DATA_W-1:0] aData,
  input  logic [TAG_W-1:0]  aTag,
  input  logic              bWrEn,
  input  logic [DATA_W-1:0] bData,
  input  logic [TAG_W-1:0]  bTag,
  input  logic              tolWe,
  input  logic [DATA_W-1:0] tolIn,
  input  logic              gapWe,
  input  logic [GAP_W-1:0]  gapIn,
  input  logic              clrWe,
  input  logic [ERR_N-1:0]  clrMask,
  output logic              mismatchErr,
  output logic              timeoutErr,
  output logic              seqErr,
  output logic [4:0]        statusOut
);
  dp_ctrl_t ctrl;
  logic overTol, tagDiff, gapHit, pendA, pendB;
  logic [ERR_N-1:0] errFlags;

  lsc_datapath #(.DATA_W(DATA_W), .TAG_W(TAG_W), .GAP_W(GAP_W)) u_dp (
    .clk, .rstN, .ctrl, .aData, .aTag, .bData, .bTag,
    .tolWe, .tolIn, .gapWe, .gapIn, .overTol, .tagDiff, .gapHit
  );

  lsc_control u_ctl (
    .clk, .rstN, .aWrEn, .bWrEn, .overTol, .tagDiff, .gapHit,
    .clrWe, .clrMask, .ctrl, .errFlags, .pendA, .pendB
  );

  assign mismatchErr = errFlags[ERR_MIS];
  assign timeoutErr  = errFlags[ERR_TMO];
  assign seqErr      = errFlags[ERR_SEQ];
  assign statusOut   = {pendB, pendA, errFlags};
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       aWrEn,
  input logic       bWrEn,
  input logic       clrWe,
  input logic [2:0] clrMask,
  input logic       mismatchErr,
  input logic       timeoutErr,
  input logic       seqErr,
  input logic [4:0] statusOut
);
  // R3: at most one side waits at a time
  assert_one_side_waits_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(statusOut[3] && statusOut[4]));

  // R1: a mismatch appears only after a submission
  assert_mismatch_needs_submit_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mismatchErr) |-> $past(aWrEn || bWrEn));

  // R6: a timeout arises only from a waiting pair and leaves the block idle
  assert_timeout_from_wait_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> ($past(statusOut[3] || statusOut[4]) && !statusOut[3] && !statusOut[4]));

  // R7: flags hold unless cleared
  assert_mismatch_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    mismatchErr && !(clrWe && clrMask[0]) |=> mismatchErr);
  assert_seq_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    seqErr && !(clrWe && clrMask[2]) |=> seqErr);

  // R7: clearing with no submission leaves the mismatch flag low
  assert_mismatch_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    clrWe && clrMask[0] && !aWrEn && !bWrEn |=> !mismatchErr);
endmodule

bind lockstep_cmp lsc_checker u_chk (
  .clk, .rstN, .aWrEn, .bWrEn, .clrWe, .clrMask,
  .mismatchErr, .timeoutErr, .seqErr, .statusOut
);

// File: tb/lockstep_cmp_test.sv
module lockstep_cmp_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic aWrEn = 0, bWrEn = 0, tolWe = 0, gapWe = 0, clrWe = 0;
  logic [31:0] aData = 0, bData = 0, tolIn = 0;
  logic [7:0]  aTag = 0, bTag = 0;
  logic [15:0] gapIn = 0;
  logic [2:0]  clrMask = 0;
  logic mismatchErr, timeoutErr, seqErr;
  logic [4:0] statusOut;

  int total = 0, failed = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lockstep_cmp uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic av, input logic [31:0] ad, input logic [7:0] at,
                       input logic bv, input logic [31:0] bd, input logic [7:0] bt);
    aWrEn = av; aData = ad; aTag = at;
    bWrEn = bv; bData = bd; bTag = bt;
    @(negedge clk);
    aWrEn = 0; bWrEn = 0;
  endtask

  task automatic clearFlags(input logic [2:0] m);
    clrWe = 1; clrMask = m;
    @(negedge clk);
    clrWe = 0;
  endtask

  task automatic setTol(input logic [31:0] t);
    tolWe = 1; tolIn = t; @(negedge clk); tolWe = 0;
  endtask

  task automatic setGap(input logic [15:0] g);
    gapWe = 1; gapIn = g; @(negedge clk); gapWe = 0;
  endtask

  function automatic logic expOver(input int a, input int b, input logic [31:0] t);
    longint d = longint'(a) - longint'(b);
    if (d < 0) d = -d;
    return d > longint'({32'b0, t});
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    int vals[8];
    logic [31:0] tols[4];
    vals = '{int'(32'h8000_0000), -7, -1, 0, 1, 4, 5, 32'h7FFF_FFFF};
    tols = '{32'd0, 32'd1, 32'd5, 32'hFFFF_FFFF};

    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R8 reset state
    check("R8 status after reset", 32'(statusOut), 32'h0);
    drive(1, 32'd10, 8'd1, 1, 32'd11, 8'd1);
    check("R8 tolerance resets to 0", 32'(mismatchErr), 32'd1);
    clearFlags(3'b111);
    check("R7 clear all", 32'(statusOut), 32'h0);
    // R8: gap limit 4 -> partner on edge 4 accepted
    drive(1, 32'd3, 8'd2, 0, 0, 0);
    repeat (3) @(negedge clk);
    drive(0, 0, 0, 1, 32'd3, 8'd2);
    check("R8 default gap accepts 4", {timeoutErr, statusOut[4:3]}, 32'h0);

    // R1 R2 R3 sweep
    for (int ti = 0; ti < 4; ti++) begin
      setTol(tols[ti]);
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic [7:0] tg;
          tg = 8'(i * 8 + j);
          if (((i + j) & 1) == 0) begin
            drive(1, vals[i], tg, 1, vals[j], tg);
            check("R1 same-cycle compare", 32'(mismatchErr),
                  32'(expOver(vals[i], vals[j], tols[ti])));
          end else if (i < j) begin
            drive(1, vals[i], tg, 0, 0, 0);
            check("R3 A waiting", 32'(statusOut[4:3]), 32'b01);
            drive(0, 0, 0, 1, vals[j], tg);
            check("R3 held A vs B", {mismatchErr, statusOut[4:3]},
                  {expOver(vals[i], vals[j], tols[ti]), 2'b00});
          end else begin
            drive(0, 0, 0, 1, vals[j], tg);
            check("R3 B waiting", 32'(statusOut[4:3]), 32'b10);
            drive(1, vals[i], tg, 0, 0, 0);
            check("R2 held B vs A", {mismatchErr, statusOut[4:3]},
                  {expOver(vals[i], vals[j], tols[ti]), 2'b00});
          end
          clearFlags(3'b111);
        end
      end
    end

    // R2 inclusive boundary
    setTol(32'd5);
    drive(1, 32'd100, 8'd9, 1, 32'd105, 8'd9);
    check("R2 diff equals tol", 32'(mismatchErr), 32'd0);
    drive(1, 32'd100, 8'd9, 1, 32'd106, 8'd9);
    check("R2 diff tol+1", 32'(mismatchErr), 32'd1);
    clearFlags(3'b111);

    // R4 tag mismatch, magnitude ignored
    drive(1, 32'd0, 8'd3, 1, 32'd1000, 8'd4);
    check("R4 tag differ same cycle", {mismatchErr, seqErr}, 32'b01);
    clearFlags(3'b111);
    drive(0, 0, 0, 1, 32'd7, 8'd5);
    drive(1, 32'd7, 8'd6, 0, 0, 0);
    check("R4 tag differ split", {mismatchErr, seqErr, statusOut[4:3]}, 32'b0100);
    clearFlags(3'b111);

    // R5 repeat replaces held and restarts window
    setGap(16'd2);
    drive(1, 32'd10, 8'd1, 0, 0, 0);
    @(negedge clk);
    drive(1, 32'd50, 8'd1, 0, 0, 0);
    check("R5 repeat sets seq", {seqErr, statusOut[4:3]}, 32'b101);
    clearFlags(3'b100);
    drive(0, 0, 0, 1, 32'd50, 8'd1);
    check("R5 replaced value, window restarted", {mismatchErr, timeoutErr, seqErr, statusOut[4:3]}, 32'h0);

    // R9 overlap: pair closes while new pair starts
    setGap(16'd4);
    drive(1, 32'd100, 8'd1, 0, 0, 0);
    drive(1, 32'd200, 8'd2, 1, 32'd103, 8'd1);
    check("R9 first pair ok, A waits again", {mismatchErr, seqErr, statusOut[4:3]}, 32'b0001);
    drive(0, 0, 0, 1, 32'd300, 8'd2);
    check("R9 second pair mismatches", {mismatchErr, statusOut[4:3]}, 32'b100);
    clearFlags(3'b111);

    // R7 set wins over clear, masks are independent
    drive(1, 32'd0, 8'd1, 1, 32'd99, 8'd1);
    clrWe = 1; clrMask = 3'b001;
    drive(1, 32'd0, 8'd1, 1, 32'd99, 8'd1);
    clrWe = 0;
    check("R7 set beats clear", 32'(mismatchErr), 32'd1);
    clearFlags(3'b110);
    check("R7 other mask bits leave mismatch", 32'(mismatchErr), 32'd1);
    clearFlags(3'b001);
    check("R7 mismatch cleared", 32'(mismatchErr), 32'd0);

    // R6 timeout offsets around the limit
    foreach (tols[gi]) begin
      int g;
      g = (gi == 0) ? 0 : (gi == 1) ? 1 : (gi == 2) ? 3 : 6;
      setGap(16'(g));
      for (int k = 0; k <= g + 1; k++) begin
        clearFlags(3'b111);
        if (k == 0) begin
          drive(1, 32'd5, 8'd7, 1, 32'd5, 8'd7);
        end else begin
          drive(1, 32'd5, 8'd7, 0, 0, 0);
          repeat (k - 1) @(negedge clk);
          drive(0, 0, 0, 1, 32'd5, 8'd7);
        end
        check($sformatf("R6 gap=%0d offset=%0d", g, k),
              {timeoutErr, statusOut[4:3]}, {(k > g), 2'b00});
      end
    end

    // R6 no partner at all
    setGap(16'd3);
    clearFlags(3'b111);
    drive(0, 0, 0, 1, 32'd1, 8'd1);
    repeat (3) @(negedge clk);
    check("R6 still waiting at limit", {timeoutErr, statusOut[4:3]}, 32'b010);
    @(negedge clk);
    check("R6 expired", {timeoutErr, statusOut[4:3]}, 32'b100);
    clearFlags(3'b010);
    check("R7 timeout cleared", 32'(statusOut), 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule